// File: doc/BRIEF.md
# MAC Statistics Counter Bank

This block holds six 32-bit event counters for an Ethernet MAC: good frames sent, good frames sent after exactly one collision, good frames sent after several collisions, received frames with a CRC error, received frames with an alignment error, and good unicast frames received. The frame logic around it raises a single-cycle strobe for each event, and the block counts it.

Software reaches the bank through a simple register port. The port has an address and write strobe, a read strobe and combinational read data. One control register selects how the counters behave. They can be cleared together, frozen, cleared as they are read, or made to stop at full scale instead of wrapping. When a counter climbs to half of its full scale, it sets a sticky status bit. The bits sit in a receive status register and a transmit status register. Each status register has a mask register beside it. A single interrupt output goes high while any unmasked status bit is set.

Top module: `mmc_stat_bank`

## Requirements
- R1: Each event strobe adds one to its own counter on the clock edge where it is high. The counters are read at word addresses 5 to 10 in this order: tx good, tx single collision, tx multiple collision, rx CRC error, rx alignment error, rx good unicast. Bit i of the event vector the bench drives maps to the counter at address 5+i.
- R2: Writing 1 to control bit 0 (address 0) sets a clear pulse. On the following edge all counters go to zero. Control bit 0 reads 1 for that one cycle and 0 afterwards.
- R3: While control bit 3 (freeze) is set, events do not change any counter and a read does not clear one. A register write still loads a counter.
- R4: While control bit 2 (clear on read) is set, reading a counter returns its value and clears it on the same edge. An event in the same cycle as that read leaves the counter at 1.
- R5: With control bit 1 (stop at maximum) set, a counter at all ones stays at all ones when an event arrives. With the bit clear, the counter wraps to zero.
- R6: A counter that increments to exactly 2^31 sets its status bit. The receive status is at address 1: unicast at bit 17, alignment at bit 6, CRC at bit 5. The transmit status is at address 2: good at bit 21, multiple collision at bit 15, single collision at bit 14. A bit stays set until its register is read, and the read clears it on that edge. Writes to the status addresses are ignored.
- R7: The mask registers are at addresses 3 (receive) and 4 (transmit) and use the same bit positions as the status registers. Only those bits are kept. irq_o is high exactly when a status bit is set and its mask bit is clear.
- R8: A write to a counter address loads the written value. If an event arrives in the same cycle, the write takes precedence.
- R9: After reset every register reads zero and irq_o is low. Reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_good_i | input | 1 | Good frame sent strobe |
| tx_one_col_i | input | 1 | Good frame sent after one collision strobe |
| tx_multi_col_i | input | 1 | Good frame sent after several collisions strobe |
| rx_crc_err_i | input | 1 | Received frame with CRC error strobe |
| rx_align_err_i | input | 1 | Received frame with alignment error strobe |
| rx_ucast_i | input | 1 | Good unicast frame received strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rd_i | input | 1 | Register read strobe (read side effects on this edge) |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench drives a counter to one below half scale and steps it over the threshold. A design that compares against the wrong threshold, or that also raises the flag on a wrap, would set the status bit in the wrong place. It checks a clear-on-read read that lands together with an event. A design that gives the clear priority would lose that event and read back 0 where 1 is expected. It checks freeze combined with clear on read, so a design that still clears frozen counters would read zero. It also checks saturation against wrapping, the one-cycle life of the clear bit, and masked status bits that must stay set while irq_o stays low.

// File: rtl/mmc_pkg.sv
package mmc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int N_CNT  = 6;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_RX_ST = 4'd1;
  localparam logic [ADDR_W-1:0] A_TX_ST = 4'd2;
  localparam logic [ADDR_W-1:0] A_RX_MK = 4'd3;
  localparam logic [ADDR_W-1:0] A_TX_MK = 4'd4;
  localparam logic [ADDR_W-1:0] A_CNT0  = 4'd5;

  // control bits
  localparam int CTL_CLR = 0;
  localparam int CTL_SAT = 1;
  localparam int CTL_ROR = 2;
  localparam int CTL_FRZ = 3;

  // counter indices
  localparam int C_TX_GOOD  = 0;
  localparam int C_TX_ONE   = 1;
  localparam int C_TX_MULTI = 2;
  localparam int C_RX_CRC   = 3;
  localparam int C_RX_ALIGN = 4;
  localparam int C_RX_UCAST = 5;

  // status bit positions (software-visible)
  localparam int SB_TX_GOOD  = 21;
  localparam int SB_TX_ONE   = 14;
  localparam int SB_TX_MULTI = 15;
  localparam int SB_RX_CRC   = 5;
  localparam int SB_RX_ALIGN = 6;
  localparam int SB_RX_UCAST = 17;
endpackage

// File: rtl/mmc_counter.sv
module mmc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             frz_i,
  input  logic             sat_i,
  input  logic             rd_clr_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             ev_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             half_o
);
  localparam logic [CNT_W-1:0] CMAX    = '1;
  localparam logic [CNT_W-1:0] HALF_M1 = {1'b0, {(CNT_W-1){1'b1}}};

  logic [CNT_W-1:0] cnt_q, base, nxt;
  logic             inc;

  // clear-on-read empties the base first so a coincident event lands on zero
  always_comb begin
    base = rd_clr_i ? '0 : cnt_q;
    inc  = ev_i && !(sat_i && (base == CMAX));
    nxt  = inc ? base + CNT_W'(1) : base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (ld_i)   cnt_q <= ld_val_i;
    else if (!frz_i) cnt_q <= nxt;
  end

  assign cnt_o  = cnt_q;
  assign half_o = inc && !clr_i && !ld_i && !frz_i && (base == HALF_M1);
endmodule

// File: rtl/mmc_irq_bank.sv
module mmc_irq_bank #(
  parameter int DW = 32,
  parameter int B0 = 0,
  parameter int B1 = 1,
  parameter int B2 = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    hit_i,
  input  logic          rd_clr_i,
  input  logic          mask_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] st_o,
  output logic [DW-1:0] mask_o,
  output logic          pend_o
);
  localparam int POS [3] = '{B0, B1, B2};

  logic [2:0] st_q, mk_q, mk_d;

  always_comb begin
    for (int k = 0; k < 3; k++) mk_d[k] = wdata_i[POS[k]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
      mk_q <= '0;
    end else begin
      st_q <= (rd_clr_i ? 3'b000 : st_q) | hit_i;  // a new hit survives the clearing read
      if (mask_wr_i) mk_q <= mk_d;
    end
  end

  always_comb begin
    st_o   = '0;
    mask_o = '0;
    for (int k = 0; k < 3; k++) begin
      st_o[POS[k]]   = st_q[k];
      mask_o[POS[k]] = mk_q[k];
    end
  end

  assign pend_o = |(st_q & ~mk_q);
endmodule

// File: rtl/mmc_stat_bank.sv
module mmc_stat_bank
  import mmc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_good_i,
  input  logic              tx_one_col_i,
  input  logic              tx_multi_col_i,
  input  logic              rx_crc_err_i,
  input  logic              rx_align_err_i,
  input  logic              rx_ucast_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              reg_rd_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic clr_q, sat_q, ror_q, frz_q;
  logic [N_CNT-1:0]            ev_vec, half_vec;
  logic [N_CNT-1:0][CNT_W-1:0] cnt_w;
  logic [DATA_W-1:0]           rx_st, tx_st, rx_mk, tx_mk;
  logic                        rx_pend, tx_pend;

  assign ev_vec[C_TX_GOOD]  = tx_good_i;
  assign ev_vec[C_TX_ONE]   = tx_one_col_i;
  assign ev_vec[C_TX_MULTI] = tx_multi_col_i;
  assign ev_vec[C_RX_CRC]   = rx_crc_err_i;
  assign ev_vec[C_RX_ALIGN] = rx_align_err_i;
  assign ev_vec[C_RX_UCAST] = rx_ucast_i;

  wire ctrl_wr = reg_wr_i && (reg_addr_i == A_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_q <= 1'b0;
      sat_q <= 1'b0;
      ror_q <= 1'b0;
      frz_q <= 1'b0;
    end else if (ctrl_wr) begin
      clr_q <= reg_wdata_i[CTL_CLR];
      sat_q <= reg_wdata_i[CTL_SAT];
      ror_q <= reg_wdata_i[CTL_ROR];
      frz_q <= reg_wdata_i[CTL_FRZ];
    end else begin
      clr_q <= 1'b0;  // self-clearing pulse
    end
  end

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    localparam logic [ADDR_W-1:0] AI = A_CNT0 + ADDR_W'(i);
    wire sel = (reg_addr_i == AI);
    mmc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (clr_q),
      .frz_i    (frz_q),
      .sat_i    (sat_q),
      .rd_clr_i (reg_rd_i && ror_q && sel),
      .ld_i     (reg_wr_i && sel),
      .ld_val_i (reg_wdata_i[CNT_W-1:0]),
      .ev_i     (ev_vec[i]),
      .cnt_o    (cnt_w[i]),
      .half_o   (half_vec[i])
    );
  end

  mmc_irq_bank #(.DW(DATA_W), .B0(SB_RX_CRC), .B1(SB_RX_ALIGN), .B2(SB_RX_UCAST)) u_rx_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     ({half_vec[C_RX_UCAST], half_vec[C_RX_ALIGN], half_vec[C_RX_CRC]}),
    .rd_clr_i  (reg_rd_i && (reg_addr_i == A_RX_ST)),
    .mask_wr_i (reg_wr_i && (reg_addr_i == A_RX_MK)),
    .wdata_i   (reg_wdata_i),
    .st_o      (rx_st),
    .mask_o    (rx_mk),
    .pend_o    (rx_pend)
  );

  mmc_irq_bank #(.DW(DATA_W), .B0(SB_TX_GOOD), .B1(SB_TX_ONE), .B2(SB_TX_MULTI)) u_tx_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     ({half_vec[C_TX_MULTI], half_vec[C_TX_ONE], half_vec[C_TX_GOOD]}),
    .rd_clr_i  (reg_rd_i && (reg_addr_i == A_TX_ST)),
    .mask_wr_i (reg_wr_i && (reg_addr_i == A_TX_MK)),
    .wdata_i   (reg_wdata_i),
    .st_o      (tx_st),
    .mask_o    (tx_mk),
    .pend_o    (tx_pend)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL: begin
        reg_rdata_o[CTL_CLR] = clr_q;
        reg_rdata_o[CTL_SAT] = sat_q;
        reg_rdata_o[CTL_ROR] = ror_q;
        reg_rdata_o[CTL_FRZ] = frz_q;
      end
      A_RX_ST: reg_rdata_o = rx_st;
      A_TX_ST: reg_rdata_o = tx_st;
      A_RX_MK: reg_rdata_o = rx_mk;
      A_TX_MK: reg_rdata_o = tx_mk;
      default: begin
        for (int i = 0; i < N_CNT; i++)
          if (reg_addr_i == A_CNT0 + ADDR_W'(i)) reg_rdata_o[CNT_W-1:0] = cnt_w[i];
      end
    endcase
  end

  assign irq_o = rx_pend | tx_pend;
endmodule

// File: rtl/mmc_stat_chk.sv
module mmc_stat_chk
  import mmc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [N_CNT-1:0]            ev_i,
  input logic                        clr_i,
  input logic                        sat_i,
  input logic                        ror_i,
  input logic                        frz_i,
  input logic [ADDR_W-1:0]           addr_i,
  input logic                        wr_i,
  input logic                        rd_i,
  input logic [N_CNT-1:0][CNT_W-1:0] cnt_i,
  input logic [DATA_W-1:0]           rx_st_i,
  input logic [DATA_W-1:0]           tx_st_i,
  input logic [DATA_W-1:0]           rx_mk_i,
  input logic [DATA_W-1:0]           tx_mk_i,
  input logic                        irq_i
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  for (genvar i = 0; i < N_CNT; i++) begin : g_chk
    localparam logic [ADDR_W-1:0] AI = A_CNT0 + ADDR_W'(i);
    wire touched = (wr_i && addr_i == AI) || (rd_i && ror_i && addr_i == AI);

    p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_i[i] && !clr_i && !frz_i && !touched && cnt_i[i] != CMAX)
      |=> cnt_i[i] == $past(cnt_i[i]) + CNT_W'(1));

    p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> cnt_i[i] == '0);

    p_freeze_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frz_i && !clr_i && !(wr_i && addr_i == AI)) |=> $stable(cnt_i[i]));

    p_no_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sat_i && !clr_i && !touched && cnt_i[i] == CMAX) |=> cnt_i[i] == CMAX);
  end

  p_sticky_rx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && addr_i == A_RX_ST) |=> (rx_st_i & $past(rx_st_i)) == $past(rx_st_i));

  p_sticky_tx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && addr_i == A_TX_ST) |=> (tx_st_i & $past(tx_st_i)) == $past(tx_st_i));

  p_irq_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rx_st_i & ~rx_mk_i) == '0 && (tx_st_i & ~tx_mk_i) == '0) |-> !irq_i);
endmodule

bind mmc_stat_bank mmc_stat_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ev_i    (ev_vec),
  .clr_i   (clr_q),
  .sat_i   (sat_q),
  .ror_i   (ror_q),
  .frz_i   (frz_q),
  .addr_i  (reg_addr_i),
  .wr_i    (reg_wr_i),
  .rd_i    (reg_rd_i),
  .cnt_i   (cnt_w),
  .rx_st_i (rx_st),
  .tx_st_i (tx_st),
  .rx_mk_i (rx_mk),
  .tx_mk_i (tx_mk),
  .irq_i   (irq_o)
);

// File: tb/mmc_stat_bank_bench.sv
`timescale 1ns/1ps
module mmc_stat_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  ev = '0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  mmc_stat_bank u_mmc_stat_bank (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .tx_good_i      (ev[0]),
    .tx_one_col_i   (ev[1]),
    .tx_multi_col_i (ev[2]),
    .rx_crc_err_i   (ev[3]),
    .rx_align_err_i (ev[4]),
    .rx_ucast_i     (ev[5]),
    .reg_addr_i     (addr),
    .reg_wr_i       (wr),
    .reg_wdata_i    (wdata),
    .reg_rd_i       (rd),
    .reg_rdata_o    (rdata),
    .irq_o          (irq)
  );

  // {op, addr, data, expected}; op 0 write, 1 read-check, 2 event
  localparam int NV = 14;
  localparam logic [69:0] TBL [NV] = '{
    {2'd2, 4'd0,  32'h1,        32'h0},
    {2'd2, 4'd0,  32'h1,        32'h0},
    {2'd2, 4'd0,  32'h20,       32'h0},
    {2'd2, 4'd0,  32'h3F,       32'h0},
    {2'd1, 4'd5,  32'h0,        32'd3},
    {2'd1, 4'd6,  32'h0,        32'd1},
    {2'd1, 4'd7,  32'h0,        32'd1},
    {2'd1, 4'd8,  32'h0,        32'd1},
    {2'd1, 4'd9,  32'h0,        32'd1},
    {2'd1, 4'd10, 32'h0,        32'd2},
    {2'd0, 4'd3,  32'hFFFFFFFF, 32'h0},
    {2'd1, 4'd3,  32'h0,        32'h00020060},
    {2'd0, 4'd4,  32'hFFFFFFFF, 32'h0},
    {2'd1, 4'd4,  32'h0,        32'h0020C000}
  };

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_op(input logic [3:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic rd_op(input logic [3:0] a, input logic [31:0] exp, input string tag);
    rd = 1'b1; addr = a;
    #1 chk(rdata, exp, tag);
    @(posedge clk); #1;
    rd = 1'b0;
  endtask

  task automatic ev_op(input logic [5:0] m);
    ev = m;
    @(posedge clk); #1;
    ev = '0;
  endtask

  task automatic wr_ev_op(input logic [3:0] a, input logic [31:0] d, input logic [5:0] m);
    wr = 1'b1; addr = a; wdata = d; ev = m;
    @(posedge clk); #1;
    wr = 1'b0; ev = '0;
  endtask

  task automatic rd_ev_op(input logic [3:0] a, input logic [5:0] m, input logic [31:0] exp, input string tag);
    rd = 1'b1; addr = a; ev = m;
    #1 chk(rdata, exp, tag);
    @(posedge clk); #1;
    rd = 1'b0; ev = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R9 reset state
    for (int a = 0; a < 16; a++) rd_op(4'(a), 32'h0, "R9");
    chk({31'b0, irq}, 32'h0, "R9");

    // R1 / R7 table
    for (int i = 0; i < NV; i++) begin
      case (TBL[i][69:68])
        2'd0: wr_op(TBL[i][67:64], TBL[i][63:32]);
        2'd1: rd_op(TBL[i][67:64], TBL[i][31:0], "R1/R7 table");
        default: ev_op(TBL[i][37:32]);
      endcase
    end
    wr_op(4'd3, 32'h0);
    wr_op(4'd4, 32'h0);

    // R2 clear pulse
    wr_op(4'd0, 32'h1);
    rd_op(4'd0, 32'h1, "R2");
    rd_op(4'd0, 32'h0, "R2");
    rd_op(4'd5, 32'h0, "R2");
    rd_op(4'd10, 32'h0, "R2");

    // R8 load, load beats event
    wr_op(4'd6, 32'h1234);
    rd_op(4'd6, 32'h1234, "R8");
    wr_ev_op(4'd6, 32'h50, 6'b000010);
    rd_op(4'd6, 32'h50, "R8");

    // R5 saturate vs wrap
    wr_op(4'd0, 32'h2);
    wr_op(4'd7, 32'hFFFFFFFF);
    ev_op(6'b000100);
    rd_op(4'd7, 32'hFFFFFFFF, "R5");
    wr_op(4'd0, 32'h0);
    ev_op(6'b000100);
    rd_op(4'd7, 32'h0, "R5");
    rd_op(4'd2, 32'h0, "R6 no flag on wrap");

    // R6 / R7 half-scale flags
    wr_op(4'd5, 32'h7FFFFFFF);
    ev_op(6'b000001);
    chk({31'b0, irq}, 32'h1, "R7");
    rd_op(4'd2, 32'h00200000, "R6");
    chk({31'b0, irq}, 32'h0, "R7");
    rd_op(4'd2, 32'h0, "R6");
    wr_op(4'd2, 32'hFFFFFFFF);
    rd_op(4'd2, 32'h0, "R6 status write ignored");
    wr_op(4'd10, 32'h7FFFFFFF);
    wr_op(4'd8, 32'h7FFFFFFF);
    ev_op(6'b101000);
    rd_op(4'd10, 32'h80000000, "R6");
    rd_op(4'd1, 32'h00020020, "R6");
    wr_op(4'd4, 32'h00200000);
    wr_op(4'd5, 32'h7FFFFFFF);
    ev_op(6'b000001);
    chk({31'b0, irq}, 32'h0, "R7 masked");
    rd_op(4'd2, 32'h00200000, "R7 masked status");
    wr_op(4'd4, 32'h0);

    // R4 clear on read
    wr_op(4'd0, 32'h4);
    wr_op(4'd9, 32'd5);
    rd_op(4'd9, 32'd5, "R4");
    rd_op(4'd9, 32'd0, "R4");
    wr_op(4'd9, 32'd5);
    rd_ev_op(4'd9, 6'b010000, 32'd5, "R4");
    rd_op(4'd9, 32'd1, "R4 coincident event");
    rd_op(4'd9, 32'd0, "R4");
    wr_op(4'd0, 32'h0);

    // R3 freeze
    wr_op(4'd0, 32'h8);
    wr_op(4'd8, 32'd9);
    ev_op(6'b111111);
    rd_op(4'd8, 32'd9, "R3");
    wr_op(4'd0, 32'hC);
    rd_op(4'd8, 32'd9, "R3");
    rd_op(4'd8, 32'd9, "R3 no clear when frozen");
    wr_op(4'd0, 32'h0);
    ev_op(6'b001000);
    rd_op(4'd8, 32'd10, "R3");

    done = 1'b1;
    report();
  end
endmodule